// File: doc/BRIEF.md
# DMA Remapping Page-Walk Engine

This block sits between I/O devices and system memory and turns each device DMA address into a system-physical address. A request carries the 16-bit identity of the issuing device, a 64-bit device-side address and a read/write flag. The engine uses the device identity to pick a 128-bit context entry from a table in memory. That entry supplies the root of the device's own four-level page-table hierarchy. The engine then walks the hierarchy one 64-bit entry at a time over a simple memory read port. It returns either the translated address with its coherency (snoop) attribute or a fault record. A faulting DMA never produces an address. Its requestor, address, direction and a reason code are reported instead.

Only one request is in flight at a time. Requests and responses each use a valid/ready handshake. The memory port holds its request and address until the memory acknowledges it, and data arrives in the acknowledge cycle. Every translation is walked in full, and no results are kept between requests.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset the engine is idle: `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R2: The requestor ID is laid out as bus in bits 15:8, device in bits 7:3 and function in bits 2:0. The whole 16-bit value indexes the context table. The first memory read of a request is at `ctx_base_i + rid*16` (low half of the entry), and the second read is at that address plus 8 (high half). Devices with different IDs therefore walk different hierarchies.
- R3: Bit 0 of the context low word is the present bit. When it is 0, the response is a fault with reason 1, and no further reads are issued.
- R4: In the context high word, bits 2:0 give the table depth, and only value 2 (four levels) is accepted. Any other value gives fault reason 2 with no page-table read. Bits 23:8 are the domain ID, which is returned on `rsp_did_o` once the high word has been read (and is 0 before that).
- R5: If address bits 63:48 are not all zero, the response is fault reason 3 in the cycle after acceptance, and no memory read is made.
- R6: The walk reads four levels, using address bits 47:39, 38:30, 29:21 and 20:12 as 9-bit indices. Each read is at `{base[47:12], index, 3'b000}`. The first base is bits 47:12 of the context low word, and each later base is bits 47:12 of the previous entry.
- R7: An entry at any level with read bit (bit 0) and write bit (bit 1) both 0 is not present. It gives fault reason 4 and ends the walk.
- R8: At any level, a write meeting W=0 gives fault reason 5, and a read meeting R=0 gives fault reason 6. The walk stops at that level.
- R9: A successful walk returns `rsp_fault_o`=0, reason 0, `rsp_pa_o = {leaf[47:12], addr[11:0]}` and `rsp_snoop_o` = leaf bit 11. A fault returns `rsp_pa_o`=0 and `rsp_snoop_o`=0, and a nonzero reason always goes with `rsp_fault_o`=1.
- R10: Every response echoes the requestor ID, the full 64-bit address and the access direction of its request.
- R11: A new request is accepted only while idle. A response stays valid and unchanged until `rsp_ready_i` is high. A memory request stays asserted with a stable address until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctx_base_i | input | 48 | Physical base of the context table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_rid_i | input | 16 | Requestor ID (bus/device/function) |
| req_addr_i | input | 64 | Device-side DMA address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 48 | Memory read address (8-byte aligned) |
| mem_ack_i | input | 1 | Memory read done, data valid |
| mem_rdata_i | input | 64 | Memory read data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_fault_o | output | 1 | Translation faulted |
| rsp_reason_o | output | 3 | Fault reason (0 none, 1..6 as in R3 to R8) |
| rsp_pa_o | output | 48 | Translated physical address |
| rsp_snoop_o | output | 1 | Snoop attribute of the leaf entry |
| rsp_did_o | output | 16 | Domain ID from the context entry |
| rsp_rid_o | output | 16 | Echoed requestor ID |
| rsp_addr_o | output | 64 | Echoed DMA address |
| rsp_write_o | output | 1 | Echoed access direction |

## Verification
The assertions assume the following about the inputs:
- Memory raises `mem_ack_i` only while `mem_req_o` is high, with valid data in that same cycle.
- `ctx_base_i` does not change while a request is in progress.
- Request fields stay steady while `req_valid_i` waits for `req_ready_o`.

The stimulus keeps within these limits. The bench memory model acknowledges only a pending read, for exactly one cycle, after a varying delay. The context base is set once before reset is released. Requests are driven at the falling edge and held until they are accepted.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTX_LO, ST_CTX_HI, ST_WALK, ST_DONE
  } walk_st_e;

  typedef enum logic [2:0] {
    RSN_NONE        = 3'd0,
    RSN_CTX_ABSENT  = 3'd1,
    RSN_BAD_WIDTH   = 3'd2,
    RSN_NONCANON    = 3'd3,
    RSN_NOT_PRESENT = 3'd4,
    RSN_WR_DENY     = 3'd5,
    RSN_RD_DENY     = 3'd6
  } rsn_e;

  localparam int unsigned PTE_R_BIT    = 0;
  localparam int unsigned PTE_W_BIT    = 1;
  localparam int unsigned PTE_SNP_BIT  = 11;
  localparam int unsigned CTX_P_BIT    = 0;
  localparam int unsigned CTX_AW_LSB   = 0;
  localparam int unsigned CTX_AW_W     = 3;
  localparam int unsigned CTX_DID_LSB  = 8;
  localparam logic [2:0]  AW_FOUR_LVL  = 3'd2;
endpackage

// File: rtl/dmx_idx_sel.sv
module dmx_idx_sel #(
  parameter int VA_W  = 64,
  parameter int OFF_W = 12,
  parameter int IDX_W = 9,
  parameter int LVL_N = 4,
  localparam int LVL_W = $clog2(LVL_N),
  localparam int TOP_W = OFF_W + LVL_N * IDX_W
) (
  input  logic [VA_W-1:OFF_W] va_i,
  input  logic [LVL_W-1:0]    lvl_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                noncanon_o
);
  logic [IDX_W-1:0] idx_arr [LVL_N];

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    assign idx_arr[g] = va_i[OFF_W + g*IDX_W +: IDX_W];
  end

  assign idx_o      = idx_arr[lvl_i];
  assign noncanon_o = |va_i[VA_W-1:TOP_W];
endmodule

// File: rtl/dmx_pte_check.sv
module dmx_pte_check
  import dmx_pkg::*;
(
  input  logic [1:0] rw_i,
  input  logic       wr_i,
  output logic       fault_o,
  output rsn_e       rsn_o
);
  always_comb begin
    fault_o = 1'b1;
    rsn_o   = RSN_NONE;
    if (rw_i == 2'b00)                   rsn_o = RSN_NOT_PRESENT;
    else if (wr_i && !rw_i[PTE_W_BIT])   rsn_o = RSN_WR_DENY;
    else if (!wr_i && !rw_i[PTE_R_BIT])  rsn_o = RSN_RD_DENY;
    else                                 fault_o = 1'b0;
  end
endmodule

// File: rtl/dmx_walk_ctrl.sv
module dmx_walk_ctrl
  import dmx_pkg::*;
#(
  parameter int LVL_N = 4,
  localparam int LVL_W = $clog2(LVL_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_fire_i,
  input  logic             noncanon_i,
  input  logic             ack_i,
  input  logic             ctx_present_i,
  input  logic             width_ok_i,
  input  logic             pte_fault_i,
  input  logic             rsp_fire_i,
  output walk_st_e         state_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             last_lvl_o
);
  walk_st_e         st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  assign last_lvl_o = (lvl_q == '0);

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    unique case (st_q)
      ST_IDLE:   if (req_fire_i) st_d = noncanon_i ? ST_DONE : ST_CTX_LO;
      ST_CTX_LO: if (ack_i) st_d = ctx_present_i ? ST_CTX_HI : ST_DONE;
      ST_CTX_HI: if (ack_i) begin
        st_d  = width_ok_i ? ST_WALK : ST_DONE;
        lvl_d = LVL_W'(LVL_N - 1);
      end
      ST_WALK:   if (ack_i) begin
        if (pte_fault_i || last_lvl_o) st_d = ST_DONE;
        else                           lvl_d = lvl_q - 1'b1;
      end
      ST_DONE:   if (rsp_fire_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      lvl_q <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign state_o = st_q;
  assign lvl_o   = lvl_q;
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import dmx_pkg::*;
#(
  parameter int PA_W  = 48,
  parameter int VA_W  = 64,
  parameter int RID_W = 16,
  parameter int DID_W = 16,
  parameter int LVL_N = 4,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  localparam int LVL_W = $clog2(LVL_N),
  localparam int PFN_W = PA_W - OFF_W,
  localparam int CTX_SH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PA_W-1:0]  ctx_base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [RID_W-1:0] req_rid_i,
  input  logic [VA_W-1:0]  req_addr_i,
  input  logic             req_write_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [2:0]       rsp_reason_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_snoop_o,
  output logic [DID_W-1:0] rsp_did_o,
  output logic [RID_W-1:0] rsp_rid_o,
  output logic [VA_W-1:0]  rsp_addr_o,
  output logic             rsp_write_o
);
  walk_st_e         state;
  logic [LVL_W-1:0] lvl;
  logic             last_lvl;

  logic [RID_W-1:0] rid_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PFN_W-1:0] tbl_q;
  logic             fault_q;
  rsn_e             rsn_q;
  logic [PA_W-1:0]  pa_q;
  logic             snp_q;
  logic [DID_W-1:0] did_q;

  logic             req_fire, rsp_fire, ack;
  logic             noncanon_new, noncanon_unused;
  logic [IDX_W-1:0] idx, idx_unused;
  logic             pte_fault;
  rsn_e             pte_rsn;
  logic             ctx_present, width_ok;
  logic [PA_W-1:0]  ctx_lo_addr;
  logic             unused_bits;

  assign req_ready_o = (state == ST_IDLE);
  assign rsp_valid_o = (state == ST_DONE);
  assign mem_req_o   = (state == ST_CTX_LO) || (state == ST_CTX_HI) || (state == ST_WALK);
  assign req_fire    = req_valid_i && req_ready_o;
  assign rsp_fire    = rsp_valid_o && rsp_ready_i;
  assign ack         = mem_req_o && mem_ack_i;

  assign ctx_present = mem_rdata_i[CTX_P_BIT];
  assign width_ok    = (mem_rdata_i[CTX_AW_LSB +: CTX_AW_W] == AW_FOUR_LVL);
  assign unused_bits = ^{mem_rdata_i[63:PA_W], mem_rdata_i[CTX_DID_LSB-1:CTX_AW_W]};

  // incoming address: canonical check at acceptance
  dmx_idx_sel #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LVL_N(LVL_N)) u_idx_new (
    .va_i       (req_addr_i[VA_W-1:OFF_W]),
    .lvl_i      ('0),
    .idx_o      (idx_unused),
    .noncanon_o (noncanon_new)
  );

  // held address: index for the current level
  dmx_idx_sel #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LVL_N(LVL_N)) u_idx_walk (
    .va_i       (va_q[VA_W-1:OFF_W]),
    .lvl_i      (lvl),
    .idx_o      (idx),
    .noncanon_o (noncanon_unused)
  );

  dmx_pte_check u_pte (
    .rw_i    (mem_rdata_i[PTE_W_BIT:PTE_R_BIT]),
    .wr_i    (wr_q),
    .fault_o (pte_fault),
    .rsn_o   (pte_rsn)
  );

  dmx_walk_ctrl #(.LVL_N(LVL_N)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_fire_i    (req_fire),
    .noncanon_i    (noncanon_new),
    .ack_i         (ack),
    .ctx_present_i (ctx_present),
    .width_ok_i    (width_ok),
    .pte_fault_i   (pte_fault),
    .rsp_fire_i    (rsp_fire),
    .state_o       (state),
    .lvl_o         (lvl),
    .last_lvl_o    (last_lvl)
  );

  assign ctx_lo_addr = ctx_base_i + {{(PA_W-RID_W-CTX_SH){1'b0}}, rid_q, {CTX_SH{1'b0}}};

  always_comb begin
    unique case (state)
      ST_CTX_LO: mem_addr_o = ctx_lo_addr;
      ST_CTX_HI: mem_addr_o = ctx_lo_addr + PA_W'(8);
      ST_WALK:   mem_addr_o = {tbl_q, idx, 3'b000};
      default:   mem_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rid_q   <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      tbl_q   <= '0;
      fault_q <= 1'b0;
      rsn_q   <= RSN_NONE;
      pa_q    <= '0;
      snp_q   <= 1'b0;
      did_q   <= '0;
    end else begin
      if (req_fire) begin
        rid_q   <= req_rid_i;
        va_q    <= req_addr_i;
        wr_q    <= req_write_i;
        fault_q <= noncanon_new;
        rsn_q   <= noncanon_new ? RSN_NONCANON : RSN_NONE;
        pa_q    <= '0;
        snp_q   <= 1'b0;
        did_q   <= '0;
      end
      if (ack) begin
        unique case (state)
          ST_CTX_LO: begin
            tbl_q <= mem_rdata_i[PA_W-1:OFF_W];
            if (!ctx_present) begin
              fault_q <= 1'b1;
              rsn_q   <= RSN_CTX_ABSENT;
            end
          end
          ST_CTX_HI: begin
            did_q <= mem_rdata_i[CTX_DID_LSB +: DID_W];
            if (!width_ok) begin
              fault_q <= 1'b1;
              rsn_q   <= RSN_BAD_WIDTH;
            end
          end
          ST_WALK: begin
            if (pte_fault) begin
              fault_q <= 1'b1;
              rsn_q   <= pte_rsn;
            end else begin
              tbl_q <= mem_rdata_i[PA_W-1:OFF_W];
              if (last_lvl) begin
                pa_q  <= {mem_rdata_i[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
                snp_q <= mem_rdata_i[PTE_SNP_BIT];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rsp_fault_o  = fault_q;
  assign rsp_reason_o = rsn_q;
  assign rsp_pa_o     = pa_q;
  assign rsp_snoop_o  = snp_q;
  assign rsp_did_o    = did_q;
  assign rsp_rid_o    = rid_q;
  assign rsp_addr_o   = va_q;
  assign rsp_write_o  = wr_q;
endmodule

// File: rtl/dmx_walk_chk.sv
module dmx_walk_chk #(
  parameter int PA_W = 48
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PA_W-1:0] ctx_base_i,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [15:0]     req_rid_i,
  input logic [63:0]     req_addr_i,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_ack_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic            rsp_fault_o,
  input logic [2:0]      rsp_reason_o,
  input logic [PA_W-1:0] rsp_pa_o
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  AST_NONCANON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (req_addr_i[63:48] != 16'h0)
    |=> rsp_valid_o && rsp_fault_o && (rsp_reason_o == 3'd3) && !mem_req_o); // R5

  AST_CTX_FIRST_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (req_addr_i[63:48] == 16'h0)
    |=> mem_req_o && (mem_addr_o == $past(ctx_base_i) + {{(PA_W-20){1'b0}}, $past(req_rid_i), 4'h0})); // R2

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R11

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i
    |=> rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o) && $stable(rsp_reason_o)); // R11

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o); // R11

  AST_MEM_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000)); // R6

  AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o == (rsp_reason_o != 3'd0))); // R9

  AST_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> (rsp_pa_o == '0)); // R9
endmodule

bind dma_xlate_walker dmx_walk_chk #(.PA_W(PA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctx_base_i   (ctx_base_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_rid_i    (req_rid_i),
  .req_addr_i   (req_addr_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_reason_o (rsp_reason_o),
  .rsp_pa_o     (rsp_pa_o)
);

// File: tb/sim_dma_xlate_walker.sv
module sim_dma_xlate_walker;
  localparam logic [47:0] CTX_BASE = 48'h10_0000;

  typedef struct packed {
    logic             fault;
    logic [2:0]       rsn;
    logic [47:0]      pa;
    logic             snp;
    logic [15:0]      did;
    logic [15:0]      rid;
    logic [63:0]      va;
    logic             wr;
    logic [2:0]       nrd;
    logic [5:0][47:0] rd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] ctx_base_i = CTX_BASE;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] req_rid_i = '0;
  logic [63:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        mem_req_o;
  logic [47:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic        rsp_fault_o;
  logic [2:0]  rsp_reason_o;
  logic [47:0] rsp_pa_o;
  logic        rsp_snoop_o;
  logic [15:0] rsp_did_o;
  logic [15:0] rsp_rid_o;
  logic [63:0] rsp_addr_o;
  logic        rsp_write_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] mem [logic [47:0]];
  exp_t        expq [$];
  string       tagq [$];
  logic [47:0] actq [$];

  always #5 clk = ~clk;

  dma_xlate_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctx_base_i(ctx_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_rid_i(req_rid_i),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_fault_o(rsp_fault_o),
    .rsp_reason_o(rsp_reason_o), .rsp_pa_o(rsp_pa_o), .rsp_snoop_o(rsp_snoop_o),
    .rsp_did_o(rsp_did_o), .rsp_rid_o(rsp_rid_o), .rsp_addr_o(rsp_addr_o),
    .rsp_write_o(rsp_write_o)
  );

  task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd64(input logic [47:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [47:0] tbl_base(input logic [15:0] rid, input int l);
    return 48'h20_0000 + {32'h0, rid[7:0], 8'h0} * 48'h80 + 48'(l) * 48'h1000;
  endfunction

  // expected result from the requirements
  function automatic exp_t model(input logic [15:0] rid, input logic [63:0] va, input logic wr);
    exp_t e;
    logic [63:0] w;
    logic [47:0] a, base;
    e = '0; e.rid = rid; e.va = va; e.wr = wr;
    if (va[63:48] != 16'h0) begin e.fault = 1; e.rsn = 3; return e; end
    a = CTX_BASE + {28'h0, rid, 4'h0};
    w = rd64(a); e.rd[0] = a; e.nrd = 1;
    if (!w[0]) begin e.fault = 1; e.rsn = 1; return e; end
    base = {w[47:12], 12'h0};
    a = a + 48'd8;
    w = rd64(a); e.rd[1] = a; e.nrd = 2;
    e.did = w[23:8];
    if (w[2:0] != 3'd2) begin e.fault = 1; e.rsn = 2; return e; end
    for (int l = 3; l >= 0; l--) begin
      a = base + {36'h0, va[12 + 9*l +: 9], 3'b000};
      w = rd64(a); e.rd[e.nrd] = a; e.nrd = e.nrd + 3'd1;
      if (w[1:0] == 2'b00) begin e.fault = 1; e.rsn = 4; return e; end
      if (wr && !w[1])     begin e.fault = 1; e.rsn = 5; return e; end
      if (!wr && !w[0])    begin e.fault = 1; e.rsn = 6; return e; end
      base = {w[47:12], 12'h0};
    end
    e.pa  = {w[47:12], va[11:0]};
    e.snp = w[11];
    return e;
  endfunction

  task automatic map(input logic [15:0] rid, input logic [63:0] va, input logic [1:0] leaf_rw,
                     input logic snp, input logic [35:0] pfn, input int bad_lvl,
                     input logic [1:0] bad_rw, input logic [2:0] aw, input logic [15:0] did);
    logic [47:0] a0, nb;
    a0 = CTX_BASE + {28'h0, rid, 4'h0};
    nb = tbl_base(rid, 3);
    mem[a0]         = {16'h0, nb[47:12], 12'h001};
    mem[a0 + 48'd8] = {40'h0, did, 5'h0, aw};
    for (int l = 3; l >= 1; l--) begin
      nb = tbl_base(rid, l - 1);
      mem[tbl_base(rid, l) + {36'h0, va[12 + 9*l +: 9], 3'b000}] =
        {16'h0, nb[47:12], 10'h0, (l == bad_lvl) ? bad_rw : 2'b11};
    end
    mem[tbl_base(rid, 0) + {36'h0, va[20:12], 3'b000}] = {16'h0, pfn, snp, 9'h0, leaf_rw};
  endtask

  // driver: push expected, drive request, wait for scoreboard to drain
  task automatic send(input logic [15:0] rid, input logic [63:0] va, input logic wr, input string tag);
    expq.push_back(model(rid, va, wr));
    tagq.push_back(tag);
    @(negedge clk);
    req_rid_i = rid; req_addr_i = va; req_write_i = wr; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check(!req_ready_o, "R11 busy after accept", {127'h0, req_ready_o}, 128'h0);
    while (expq.size() != 0) @(negedge clk);
  endtask

  // memory model: ack one cycle, varying latency
  int wait_cnt = 0;
  int lat_pat = 0;
  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (rst_n && mem_req_o) begin
      if (wait_cnt == 0) begin
        mem_ack_i   = 1'b1;
        mem_rdata_i = rd64(mem_addr_o);
        actq.push_back(mem_addr_o);
        wait_cnt = lat_pat;
        lat_pat  = (lat_pat + 1) % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  // monitor: backpressure and compare
  int stall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      rsp_ready_i = ((stall % 5) != 2) && ((stall % 5) != 3);
      stall++;
      if (rsp_valid_o && rsp_ready_i) begin
        if (expq.size() == 0) begin
          check(1'b0, "R11 unexpected response", 128'h1, 128'h0);
        end else begin
          exp_t  e;
          string t;
          logic  ok;
          e = expq[0];
          t = tagq.pop_front();
          check(rsp_fault_o == e.fault && rsp_reason_o == e.rsn, t,
                {124'h0, rsp_fault_o, rsp_reason_o}, {124'h0, e.fault, e.rsn});
          check(rsp_pa_o == e.pa && rsp_snoop_o == e.snp, "R9 pa/snoop",
                {79'h0, rsp_snoop_o, rsp_pa_o}, {79'h0, e.snp, e.pa});
          check(rsp_did_o == e.did, "R4 domain id", {112'h0, rsp_did_o}, {112'h0, e.did});
          check(rsp_rid_o == e.rid && rsp_addr_o == e.va && rsp_write_o == e.wr, "R10 echo",
                {47'h0, rsp_write_o, rsp_rid_o, rsp_addr_o}, {47'h0, e.wr, e.rid, e.va});
          if (e.nrd != 0)
            check(actq.size() > 0 && actq[0] == e.rd[0], "R2 context address",
                  {80'h0, (actq.size() > 0) ? actq[0] : 48'h0}, {80'h0, e.rd[0]});
          ok = (actq.size() == int'(e.nrd));
          for (int i = 0; i < 6; i++)
            if (ok && i < int'(e.nrd) && actq[i] != e.rd[i]) ok = 1'b0;
          check(ok, "R6 read sequence", 128'(actq.size()), 128'(e.nrd));
          actq.delete();
          void'(expq.pop_front());
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 128'h0, 128'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready_o && !rsp_valid_o && !mem_req_o, "R1 reset",
          {125'h0, req_ready_o, rsp_valid_o, mem_req_o}, {125'h0, 3'b100});
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready_o && !rsp_valid_o && !mem_req_o, "R1 after reset",
          {125'h0, req_ready_o, rsp_valid_o, mem_req_o}, {125'h0, 3'b100});

    // R9: full walk, read then write
    map(16'h1234, 64'h0000_1234_5678_9ABC, 2'b11, 1'b1, 36'hABCDE1234, -1, 2'b11, 3'd2, 16'h0055);
    send(16'h1234, 64'h0000_1234_5678_9ABC, 1'b0, "R9 read ok");
    send(16'h1234, 64'h0000_1234_5678_9ABC, 1'b1, "R9 write ok");
    // R2: other function on same bus/device, own tables
    map(16'h1235, 64'h0000_1234_5678_9ABC, 2'b11, 1'b0, 36'h000777000, -1, 2'b11, 3'd2, 16'h0066);
    send(16'h1235, 64'h0000_1234_5678_9ABC, 1'b0, "R2 per-device table");
    send(16'h1234, 64'h0000_1234_5678_9ABC, 1'b0, "R2 first device unchanged");
    // R6: all index bits high
    map(16'h0A0F, 64'h0000_FFFF_FFFF_FFFF, 2'b01, 1'b1, 36'h123456789, -1, 2'b11, 3'd2, 16'hBEEF);
    send(16'h0A0F, 64'h0000_FFFF_FFFF_FFFF, 1'b0, "R6 max indices");
    // R8: permission denials
    send(16'h0A0F, 64'h0000_FFFF_FFFF_FFFF, 1'b1, "R8 write denied");
    map(16'h0A0F, 64'h0000_FFFF_FFFF_FFFF, 2'b10, 1'b1, 36'h123456789, -1, 2'b11, 3'd2, 16'hBEEF);
    send(16'h0A0F, 64'h0000_FFFF_FFFF_FFFF, 1'b0, "R8 read denied");
    send(16'h0A0F, 64'h0000_FFFF_FFFF_FFFF, 1'b1, "R8 write-only ok");
    map(16'h0301, 64'h0000_0080_4020_1000, 2'b11, 1'b0, 36'h000000ABC, 3, 2'b01, 3'd2, 16'h0007);
    send(16'h0301, 64'h0000_0080_4020_1000, 1'b1, "R8 top level write denied");
    // R7: not-present leaf and middle level
    map(16'h0302, 64'h0000_0000_0000_5FFF, 2'b00, 1'b1, 36'h000000ABC, -1, 2'b11, 3'd2, 16'h0008);
    send(16'h0302, 64'h0000_0000_0000_5FFF, 1'b0, "R7 leaf not present");
    map(16'h0303, 64'h0000_0040_2010_0000, 2'b11, 1'b1, 36'h000000ABC, 2, 2'b00, 3'd2, 16'h0009);
    send(16'h0303, 64'h0000_0040_2010_0000, 1'b1, "R7 middle not present");
    // R5: upper bits set
    send(16'h1234, 64'h0001_0000_0000_0000, 1'b0, "R5 upper bits");
    send(16'h1234, 64'h8000_1234_5678_9ABC, 1'b1, "R5 top bit");
    // R3: absent context
    mem[CTX_BASE + {28'h0, 16'h7700, 4'h0}] = 64'h0000_0000_0030_0000;
    send(16'h7700, 64'h0000_0000_0000_1000, 1'b0, "R3 context absent");
    // R4: wrong table depth
    map(16'h0404, 64'h0000_0000_0000_2000, 2'b11, 1'b1, 36'h1, -1, 2'b11, 3'd1, 16'h4242);
    send(16'h0404, 64'h0000_0000_0000_2000, 1'b0, "R4 width unsupported");
    map(16'h0404, 64'h0000_0000_0000_2000, 2'b11, 1'b1, 36'h1, -1, 2'b11, 3'd2, 16'h4242);
    send(16'h0404, 64'h0000_0000_0000_2000, 1'b0, "R4 width ok");
    // R10/R11: back-to-back sequence under response backpressure
    for (int i = 0; i < 6; i++)
      send(16'h1234, 64'h0000_1234_5678_9000 + 64'(i), i[0], "R11 back to back");

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R11 all responses seen", 128'(expq.size()), 128'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule